// File: doc/BRIEF.md
# IR pulse-width symbol capture receiver

This block receives the demodulated input line of a remote-control receiver and measures each symbol as a pair of numbers. The mark length is the time the carrier is present. The period is the time from the start of one mark to the start of the next. Software derives the space length as period minus mark. Time is counted in sample ticks, which come from dividing the system clock by a programmable integer. With the default divisor of 5 and a 50 MHz clock, the tick rate is 10 MHz.

The line passes through a selectable inverter, a two-flop synchronizer and a glitch filter that discards pulses shorter than a programmed number of ticks. A mark stays open across short carrier gaps and closes once the line has been inactive for a programmed gap count. When no new mark begins before the maximum symbol period expires, the burst is over. The final symbol is then stored with an all-ones period. Completed pairs go into an eight-entry FIFO. Software reads them over a simple register bus, and reading the period register pops the entry. Four sticky event flags, each write-one-to-clear, drive a maskable interrupt.

Top module: `ir_symbol_rx`

## Requirements
- R1: After reset the following values hold: divisor = 5, maximum period = 0x5000, receiver disabled, interrupt enable = 0, event flags = 0, receive status = 0, irq_o low, and the mark register reads 0.
- R2: For a symbol whose active level lasts M ticks and is followed by S inactive ticks before the next mark, the stored mark is M and the stored period is M+S. Both are nonzero and the mark never exceeds the period.
- R3: An inactive run shorter than the gap count (0x60, default 4) does not end a mark. A run equal to the gap count does end it.
- R4: With noise length N (0x5C), a pulse of fewer than N ticks has no effect on any stored value. Genuine edges are delayed equally, so durations are unchanged.
- R5: If the period count reaches the maximum period (0x54) with no new mark, the pair is completed with period 0xFFFF, and event flag bit 1 (last symbol) is set.
- R6: The mark register (0x40) and the period register (0x44) show the FIFO head. Reading 0x44 pops the head, and the mark register then shows the next entry. Reading either register when the FIFO is empty returns 0 and changes nothing.
- R7: The FIFO holds 8 pairs. While it is full, event flag bit 3 is set. A pair completed while the FIFO is full is dropped, the stored entries stay as they are, and event flag bit 2 (overrun) is set.
- R8: Event flags at 0x4C are cleared by writing ones to 0x58, bit by bit. Writing 0x04 clears only the overrun flag. Bit 0 is set each time a pair is stored.
- R9: irq_o is high exactly when some event flag is set whose bit is also set in the interrupt enable register (0x48).
- R10: Writing 1 to the invert register (0x68) makes a low pin level count as the active level.
- R11: While the enable register (0x50) is 0, no pair is captured and no event flag is set.
- R12: The sample tick fires once every D system clocks, where D is the divisor register (0x64). All durations are counted in ticks.
- R13: The mark and period counters saturate at 0xFFFF instead of wrapping.
- R14: Receive status (0x6C) bits 15:8 hold the FIFO entry count, and bit 2 mirrors the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_line_i | input | 1 | Raw receiver pin |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe, pops the FIFO at the period offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Random bursts of one to six symbols, at several divisors and with random marks that contain a short carrier hole, check that the mark and period are taken from the right edges and not from raw line levels. Directed patterns cover a gap of exactly the gap count against one tick shorter, a sub-threshold spike in a space, an inverted pin, a disabled receiver and a ten-symbol burst into the eight-entry FIFO. Together they separate mark closing, glitch rejection, polarity, overrun dropping and flag clearing. A mark held for 70000 ticks checks that the counters saturate rather than wrap.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int unsigned TW = 16;
  localparam logic [TW-1:0] LAST_MARK = '1;
  localparam int unsigned IRQ_W = 4;
  localparam int unsigned EV_AVAIL = 0;
  localparam int unsigned EV_LAST  = 1;
  localparam int unsigned EV_OVR   = 2;
  localparam int unsigned EV_FULL  = 3;

  localparam logic [7:0] OFS_MARK  = 8'h40;
  localparam logic [7:0] OFS_PER   = 8'h44;
  localparam logic [7:0] OFS_INTEN = 8'h48;
  localparam logic [7:0] OFS_EVT   = 8'h4C;
  localparam logic [7:0] OFS_EN    = 8'h50;
  localparam logic [7:0] OFS_MAXP  = 8'h54;
  localparam logic [7:0] OFS_CLR   = 8'h58;
  localparam logic [7:0] OFS_NOISE = 8'h5C;
  localparam logic [7:0] OFS_GAP   = 8'h60;
  localparam logic [7:0] OFS_DIV   = 8'h64;
  localparam logic [7:0] OFS_INV   = 8'h68;
  localparam logic [7:0] OFS_RXST  = 8'h6C;

  typedef struct packed {
    logic [TW-1:0] mark;
    logic [TW-1:0] period;
  } ir_pair_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} meter_st_e;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R12
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > 1 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/ir_frontend.sv
module ir_frontend #(
  parameter int unsigned NS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_i,
  input  logic            invert_i,
  input  logic            tick_i,
  input  logic [NS_W-1:0] min_len_i,
  output logic            level_o
);
  logic [1:0]      sync_q;
  logic            raw;
  logic [NS_W-1:0] run_q;
  logic [NS_W:0]   run_nx;
  logic [NS_W:0]   need;

  assign raw    = sync_q[1] ^ invert_i;
  assign run_nx = {1'b0, run_q} + 1'b1;
  assign need   = (min_len_i == '0) ? (NS_W+1)'(1) : {1'b0, min_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      run_q   <= '0;
      level_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (tick_i) begin
        if (raw == level_o) run_q <= '0;
        else if (run_nx >= need) begin
          level_o <= raw;
          run_q   <= '0;
        end else run_q <= run_nx[NS_W-1:0];
      end
    end
  end

  // R4
  filt_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_o));
endmodule

// File: rtl/ir_symbol_meter.sv
module ir_symbol_meter
  import ir_rx_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             level_i,
  input  logic [GAP_W-1:0] gap_lim_i,
  input  logic [TW-1:0]    max_per_i,
  output logic             push_o,
  output logic             last_o,
  output ir_pair_t         pair_o
);
  meter_st_e        st_q, st_d;
  logic [TW-1:0]    sym_q, sym_d, mark_q, mark_d, sym_inc;
  logic [GAP_W-1:0] gap_q, gap_d, gap_inc, gap_eff;

  assign sym_inc = (sym_q == LAST_MARK) ? sym_q : sym_q + 1'b1;
  assign gap_inc = (gap_q == '1) ? gap_q : gap_q + 1'b1;
  assign gap_eff = (gap_lim_i == '0) ? GAP_W'(1) : gap_lim_i;

  always_comb begin
    st_d   = st_q;
    sym_d  = sym_q;
    mark_d = mark_q;
    gap_d  = gap_q;
    push_o = 1'b0;
    last_o = 1'b0;
    pair_o = '{mark: mark_q, period: sym_q};
    if (!en_i) st_d = ST_IDLE;
    else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: if (level_i) begin
          st_d = ST_MARK; sym_d = TW'(1); mark_d = TW'(1); gap_d = '0;
        end
        ST_MARK: begin
          sym_d = sym_inc;
          if (level_i) begin
            mark_d = sym_inc;
            gap_d  = '0;
          end else begin
            gap_d = gap_inc;
            if (gap_inc >= gap_eff) st_d = ST_SPACE;
          end
        end
        ST_SPACE: begin
          if (level_i) begin
            push_o = 1'b1;
            st_d = ST_MARK; sym_d = TW'(1); mark_d = TW'(1); gap_d = '0;
          end else begin
            sym_d = sym_inc;
            if (sym_inc >= max_per_i) begin
              push_o = 1'b1;
              last_o = 1'b1;
              pair_o.period = LAST_MARK;
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sym_q  <= '0;
      mark_q <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      sym_q  <= sym_d;
      mark_q <= mark_d;
      gap_q  <= gap_d;
    end
  end

  // R2
  mark_le_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (pair_o.mark != '0 && pair_o.mark <= pair_o.period));
  // R11
  off_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !push_o);
endmodule

// File: rtl/ir_pair_fifo.sv
module ir_pair_fifo
  import ir_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  ir_pair_t         data_i,
  input  logic             pop_i,
  output ir_pair_t         head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  ir_pair_t      mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_wr, do_rd;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_wr   = push_i && !full_o;
  assign drop_o  = push_i && full_o;
  assign do_rd   = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (do_wr && !do_rd)      count_o <= count_o + 1'b1;
      else if (do_rd && !do_wr) count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= data_i;
  end

  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R7
  drop_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !pop_i) |=> count_o == $past(count_o));
endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
  import ir_rx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned NS_W        = 8,
  parameter int unsigned GAP_W       = 8,
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned RST_DIV     = 5,
  parameter int unsigned RST_MAXP    = 'h5000,
  parameter int unsigned RST_NOISE   = 1,
  parameter int unsigned RST_GAP     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_line_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             en_q, inv_q;
  logic [IRQ_W-1:0] inten_q, evt_q, evt_set, evt_clr;
  logic [TW-1:0]    maxp_q;
  logic [NS_W-1:0]  noise_q;
  logic [GAP_W-1:0] gap_q;
  logic [DIV_W-1:0] div_q;

  logic             tick, level, push, last, pop, drop, full, empty;
  ir_pair_t         pair, head;
  logic [CNT_W-1:0] count;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:TW];

  function automatic logic at(input logic [7:0] ofs);
    return bus_addr_i == ADDR_W'(ofs);
  endfunction

  ir_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .div_i(div_q), .restart_i(bus_wr_i && at(OFS_DIV)), .tick_o(tick)
  );

  ir_frontend #(.NS_W(NS_W)) i_front (
    .clk_i, .rst_ni, .line_i(ir_line_i), .invert_i(inv_q), .tick_i(tick),
    .min_len_i(noise_q), .level_o(level)
  );

  ir_symbol_meter #(.GAP_W(GAP_W)) i_meter (
    .clk_i, .rst_ni, .en_i(en_q), .tick_i(tick), .level_i(level),
    .gap_lim_i(gap_q), .max_per_i(maxp_q), .push_o(push), .last_o(last), .pair_o(pair)
  );

  ir_pair_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(pair), .pop_i(pop), .head_o(head),
    .count_o(count), .full_o(full), .empty_o(empty), .drop_o(drop)
  );

  assign pop = bus_rd_i && at(OFS_PER) && !empty;

  always_comb begin
    evt_set           = '0;
    evt_set[EV_AVAIL] = push && !full;
    evt_set[EV_LAST]  = last;
    evt_set[EV_OVR]   = drop;
    evt_set[EV_FULL]  = full;
    evt_clr = (bus_wr_i && at(OFS_CLR)) ? bus_wdata_i[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      inv_q   <= 1'b0;
      inten_q <= '0;
      evt_q   <= '0;
      maxp_q  <= TW'(RST_MAXP);
      noise_q <= NS_W'(RST_NOISE);
      gap_q   <= GAP_W'(RST_GAP);
      div_q   <= DIV_W'(RST_DIV);
    end else begin
      evt_q <= (evt_q & ~evt_clr) | evt_set;
      if (bus_wr_i) begin
        if (at(OFS_EN))    en_q    <= bus_wdata_i[0];
        if (at(OFS_INV))   inv_q   <= bus_wdata_i[0];
        if (at(OFS_INTEN)) inten_q <= bus_wdata_i[IRQ_W-1:0];
        if (at(OFS_MAXP))  maxp_q  <= bus_wdata_i[TW-1:0];
        if (at(OFS_NOISE)) noise_q <= bus_wdata_i[NS_W-1:0];
        if (at(OFS_GAP))   gap_q   <= bus_wdata_i[GAP_W-1:0];
        if (at(OFS_DIV))   div_q   <= bus_wdata_i[DIV_W-1:0];
      end
    end
  end

  assign irq_o = |(evt_q & inten_q);

  always_comb begin
    bus_rdata_o = '0;
    unique case (1'b1)
      at(OFS_MARK):  bus_rdata_o = empty ? '0 : DATA_W'(head.mark);
      at(OFS_PER):   bus_rdata_o = empty ? '0 : DATA_W'(head.period);
      at(OFS_INTEN): bus_rdata_o = DATA_W'(inten_q);
      at(OFS_EVT):   bus_rdata_o = DATA_W'(evt_q);
      at(OFS_EN):    bus_rdata_o = DATA_W'(en_q);
      at(OFS_MAXP):  bus_rdata_o = DATA_W'(maxp_q);
      at(OFS_NOISE): bus_rdata_o = DATA_W'(noise_q);
      at(OFS_GAP):   bus_rdata_o = DATA_W'(gap_q);
      at(OFS_DIV):   bus_rdata_o = DATA_W'(div_q);
      at(OFS_INV):   bus_rdata_o = DATA_W'(inv_q);
      at(OFS_RXST):  bus_rdata_o = DATA_W'({8'(count), 5'b0, evt_q[EV_OVR], 2'b0});
      default:       bus_rdata_o = '0;
    endcase
  end

  // R7
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EV_OVR]) |-> $past(drop));
  // R8
  clr_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && at(OFS_CLR) && bus_wdata_i[EV_OVR] && !drop) |=> !evt_q[EV_OVR]);
endmodule

// File: tb/test_ir_symbol_rx.sv
module test_ir_symbol_rx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ir_line_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  int div_b = 5;
  bit inv_b = 0;
  int unsigned em[$];
  int unsigned ep[$];

  ir_symbol_rx i_ir_symbol_rx (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned exp_period(input int m, input int s, input bit last);
    return last ? 32'hFFFF : m + s;
  endfunction

  function automatic int unsigned exp_rxst(input int cnt, input bit ovr);
    return (cnt << 8) | (ovr << 2);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic hold(input bit lvl, input int ticks);
    ir_line_i = lvl ^ inv_b;
    repeat (ticks * div_b) @(negedge clk_i);
  endtask

  task automatic mark_pulse(input int m, input bit chop);
    if (chop && m >= 7) begin
      int b;
      b = 1 + $urandom_range(2);
      hold(1, 2); hold(0, b); hold(1, m - 2 - b);
    end else hold(1, m);
  endtask

  task automatic sym(input int m, input int s, input bit chop);
    mark_pulse(m, chop);
    hold(0, s);
    em.push_back(m); ep.push_back(exp_period(m, s, 0));
  endtask

  task automatic last_sym(input int m, input int maxp, input bit chop);
    mark_pulse(m, chop);
    em.push_back(m); ep.push_back(exp_period(m, 0, 1));
    hold(0, maxp + 12);
  endtask

  task automatic drain(input string req);
    logic [31:0] d;
    rd(8'h6C, d);
    chk({req, " R14 count"}, d, exp_rxst(em.size(), 0));
    rd(8'h4C, d);
    chk({req, " R5 last flag"}, d[1], 1'b1);
    while (em.size() > 0) begin
      rd(8'h40, d); chk({req, " R2 mark"}, d, em.pop_front());
      rd(8'h44, d); chk({req, " R2 period"}, d, ep.pop_front());
    end
    wr(8'h58, 32'hF);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(8'h64, d); chk("R1 divisor", d, 5);
    rd(8'h54, d); chk("R1 maxp", d, 32'h5000);
    rd(8'h50, d); chk("R1 enable", d, 0);
    rd(8'h48, d); chk("R1 inten", d, 0);
    rd(8'h4C, d); chk("R1 flags", d, 0);
    rd(8'h6C, d); chk("R1 rxst", d, 0);
    rd(8'h40, d); chk("R1 mark", d, 0);
    chk("R1 irq", irq_o, 0);

    // R11 disabled: nothing captured
    hold(0, 4); sym(6, 10, 0); last_sym(5, 32'h50, 0);
    em.delete(); ep.delete();
    rd(8'h6C, d); chk("R11 count", d, 0);
    rd(8'h4C, d); chk("R11 flags", d, 0);

    wr(8'h54, 80);
    wr(8'h50, 1);

    // R3 gap count
    hold(0, 4);
    hold(1, 3); hold(0, 3); hold(1, 3); hold(0, 12);
    em.push_back(9); ep.push_back(21);
    hold(1, 4); hold(0, 4);
    em.push_back(4); ep.push_back(8);
    last_sym(4, 80, 0);
    drain("R3");

    // R4 noise suppression
    wr(8'h5C, 3);
    hold(1, 6); hold(0, 10); hold(1, 2); hold(0, 10);
    em.push_back(6); ep.push_back(28);
    last_sym(5, 80, 0);
    drain("R4");
    wr(8'h5C, 1);

    // R12 divisor 3
    wr(8'h64, 3); div_b = 3;
    hold(0, 4);
    sym(7, 13, 0); last_sym(9, 80, 0);
    drain("R12");

    // R10 inverted pin
    wr(8'h50, 0);
    inv_b = 1; hold(0, 2);
    wr(8'h68, 1);
    hold(0, 10);
    wr(8'h50, 1);
    sym(5, 10, 0); last_sym(7, 80, 0);
    drain("R10");
    wr(8'h50, 0); inv_b = 0; wr(8'h68, 0); hold(0, 10); wr(8'h50, 1);

    // R2 random bursts
    for (int b = 0; b < 12; b++) begin
      int n;
      bit chop;
      case ($urandom_range(3))
        0: div_b = 1;
        1: div_b = 2;
        2: div_b = 3;
        default: div_b = 5;
      endcase
      wr(8'h64, div_b);
      hold(0, 6);
      n = 1 + $urandom_range(5);
      for (int k = 0; k < n - 1; k++) begin
        chop = $urandom_range(1);
        sym(4 + $urandom_range(16), 4 + $urandom_range(36), chop);
      end
      chop = $urandom_range(1);
      last_sym(4 + $urandom_range(16), 80, chop);
      drain("R2 random");
    end

    // R7 overrun, R8 clear, R9 irq
    div_b = 2; wr(8'h64, 2); wr(8'h54, 100); hold(0, 6);
    for (int k = 0; k < 9; k++) begin
      hold(1, 4); hold(0, 6);
    end
    hold(1, 4); hold(0, 112);
    rd(8'h6C, d); chk("R7 count full", d, exp_rxst(8, 1));
    rd(8'h4C, d); chk("R7 flags", d, 32'hF);
    wr(8'h58, 32'h4);
    rd(8'h4C, d); chk("R8 clear ovr only", d, 32'hB);
    rd(8'h6C, d); chk("R14 ovr mirror", d, exp_rxst(8, 0));
    wr(8'h48, 32'h4); #1 chk("R9 irq masked", irq_o, 0);
    wr(8'h48, 32'h2); #1 chk("R9 irq set", irq_o, 1);
    rd(8'h40, d); chk("R6 mark peek", d, 4);
    rd(8'h40, d); chk("R6 mark no pop", d, 4);
    for (int k = 0; k < 8; k++) begin
      rd(8'h40, d); chk("R7 kept mark", d, 4);
      rd(8'h44, d); chk("R7 kept period", d, 10);
    end
    rd(8'h44, d); chk("R6 empty period", d, 0);
    rd(8'h40, d); chk("R6 empty mark", d, 0);
    rd(8'h6C, d); chk("R6 empty count", d, 0);
    wr(8'h58, 32'hF);
    rd(8'h4C, d); chk("R8 all clear", d, 0);
    #1 chk("R9 irq low", irq_o, 0);

    // R13 saturation
    div_b = 1; wr(8'h64, 1); hold(0, 6);
    hold(1, 70000); hold(0, 112);
    rd(8'h40, d); chk("R13 mark sat", d, 32'hFFFF);
    rd(8'h44, d); chk("R13 period", d, 32'hFFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule